// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for clause 22 MDIO management transactions. Software uses it to read and write registers in external PHY devices. A small register port gives access to six registers:

- a configuration register that selects the MDC speed and holds a soft reset,
- an address register that names the PHY and the register inside it,
- a data register whose write starts a write transaction,
- a command register whose read bit starts a read transaction,
- an indicator register that shows busy,
- a status register that returns the word read.

The MDC clock is derived from the system clock. A 3-bit speed code selects a prescale of 4, 6, 8, 10, 14, 20 or 28. This is followed by a fixed divide by 8. Every transaction is a 64-bit frame, sent MSB first, and has these fields:

- a 32-bit preamble of ones,
- start bits `01`,
- an opcode: `01` for write, `10` for read,
- a 5-bit PHY address,
- a 5-bit register address,
- a 2-bit turnaround,
- 16 data bits.

The master changes MDIO after falling MDC edges and samples read data on rising MDC edges. The line is split into an output, an output enable and an input, which the pad ring combines into the bidirectional pin.

Top module: `mdio_master`

## Requirements
- R1: After reset the indicator busy bit (offset 4, bit 0) reads 0, MDC is high, MDIO is not driven, and the status register (offset 5) reads 0.
- R2: MDC period equals prescale × 8 system clocks, where configuration bits [2:0] select the prescale as follows: 1→4, 2→6, 3→8, 4→10, 5→14, 6→20, 7→28. Code 0 behaves as code 7.
- R3: A write to the data register (offset 2, bits [15:0]) sends the frame 32 ones, `01`, `01`, PHY, register, `10`, data, MSB first. The frame drives MDIO for all 64 bits.
- R4: The busy bit is 1 from the cycle after a launch until the 64th rising MDC edge of the frame. MDC stays high whenever no frame is active.
- R5: Writing command bit 0 (offset 3) from 0 to 1 sends a read header with opcode `10` and releases MDIO from bit 46 (the turnaround) onward. The master then samples 16 bits on rising MDC edges, MSB first, into status bits [15:0].
- R6: A read with no PHY driving the line (input held high) returns 0xFFFF.
- R7: A read starts only on a 0→1 change of command bit 0. Writing 1 while the bit is already 1 starts nothing.
- R8: While configuration bit 31 is 1, the divider and frame logic are held idle: busy is 0, MDC is high and MDIO is released. Clearing the bit allows new frames.
- R9: While MDIO is driven, its value changes only in the cycle in which MDC falls.
- R10: A launch (data-register write or read request) while busy is ignored, and the running frame continues unchanged.
- R11: The address register (offset 1) carries the PHY address in bits [12:8] and the register number in bits [4:0]. These are sent in that order in the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The assertions check the following on every cycle:
- MDC is high while idle,
- the divider counter stays inside its widest half period,
- a driven MDIO line changes only on MDC falling edges,
- MDIO is released during the read data phase,
- soft reset forces the idle state.

Only the bench's scenarios can show the rest:
- the exact bit content of write and read headers,
- measured MDC periods for several codes, including code 0,
- the data returned by a responding or absent PHY,
- the edge-only read launch,
- launches dropped while busy,
- recovery after soft reset.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int FIXED_DIV  = 8;
  localparam int PRE_BITS   = 32;
  localparam int BODY_BITS  = 32;
  localparam int TOTAL_BITS = PRE_BITS + BODY_BITS;
  localparam int TA_POS     = PRE_BITS + 14;
  localparam int DATA_POS   = PRE_BITS + 16;
  localparam int MAX_PRESCALE = 28;

  localparam logic [1:0] SOF_BITS = 2'b01;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] TA_WR    = 2'b10;

  typedef enum logic [2:0] {
    RA_CFG  = 3'd0,
    RA_ADDR = 3'd1,
    RA_DATA = 3'd2,
    RA_CMD  = 3'd3,
    RA_IND  = 3'd4,
    RA_STAT = 3'd5
  } reg_addr_e;

  function automatic int unsigned prescale(input logic [2:0] code);
    case (code)
      3'd1:    prescale = 4;
      3'd2:    prescale = 6;
      3'd3:    prescale = 8;
      3'd4:    prescale = 10;
      3'd5:    prescale = 14;
      3'd6:    prescale = 20;
      default: prescale = MAX_PRESCALE;
    endcase
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen
  import mdio_pkg::*;
#(
  parameter int CW = $clog2(MAX_PRESCALE * FIXED_DIV / 2)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       run,
  input  logic [2:0] code,
  output logic       mdc,
  output logic       fall_p,
  output logic       rise_p
);
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_PRESCALE * FIXED_DIV / 2 - 1);

  logic [CW-1:0] cnt_q, cnt_d, half_m1;
  logic          mdc_q, mdc_d, terminal;

  assign half_m1  = CW'(prescale(code) * (FIXED_DIV / 2) - 1);
  assign terminal = run && (cnt_q >= half_m1);
  assign fall_p   = terminal && mdc_q;
  assign rise_p   = terminal && !mdc_q;
  assign mdc      = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b1;
    end else if (terminal) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b1;
    end else if (soft_rst) begin
      cnt_q <= '0;
      mdc_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);
  a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> mdc_q);
endmodule

// File: rtl/mdio_shifter.sv
`timescale 1ns/1ps
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        soft_rst,
  input  logic        start,
  input  logic        start_rd,
  input  logic [4:0]  phy,
  input  logic [4:0]  regn,
  input  logic [15:0] wdata,
  input  logic        fall_p,
  input  logic        rise_p,
  input  logic        mdio_i,
  output logic        busy,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        rd_done,
  output logic [15:0] rx_data
);
  localparam int NB_W = $clog2(TOTAL_BITS + 1);
  localparam logic [NB_W-1:0] N_PRE  = NB_W'(PRE_BITS);
  localparam logic [NB_W-1:0] N_TA   = NB_W'(TA_POS);
  localparam logic [NB_W-1:0] N_DATA = NB_W'(DATA_POS);
  localparam logic [NB_W-1:0] N_ALL  = NB_W'(TOTAL_BITS);

  logic [NB_W-1:0]      nbit_q, nbit_d;
  logic [BODY_BITS-1:0] frm_q, frm_d;
  logic [15:0]          rx_q, rx_d;
  logic busy_q, busy_d, rd_q, rd_d, oe_q, oe_d, out_q, out_d, done;

  always_comb begin
    nbit_d = nbit_q;
    frm_d  = frm_q;
    rx_d   = rx_q;
    busy_d = busy_q;
    rd_d   = rd_q;
    oe_d   = oe_q;
    out_d  = out_q;
    done   = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        rd_d   = start_rd;
        nbit_d = '0;
        oe_d   = 1'b1;
        out_d  = 1'b1;
        frm_d  = {SOF_BITS, start_rd ? OP_RD : OP_WR, phy, regn,
                  start_rd ? 2'b11 : TA_WR, start_rd ? 16'hFFFF : wdata};
      end
    end else begin
      if (fall_p) begin
        if (nbit_q < N_PRE) begin
          out_d = 1'b1;
        end else begin
          out_d = frm_q[BODY_BITS-1];
          frm_d = {frm_q[BODY_BITS-2:0], 1'b0};
        end
        if (rd_q && nbit_q >= N_TA) oe_d = 1'b0;
        nbit_d = nbit_q + 1'b1;
      end
      if (rise_p) begin
        if (rd_q && nbit_q > N_DATA) rx_d = {rx_q[14:0], mdio_i};
        if (nbit_q == N_ALL) begin
          busy_d = 1'b0;
          oe_d   = 1'b0;
          out_d  = 1'b1;
          done   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nbit_q <= '0;
      frm_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      oe_q   <= 1'b0;
      out_q  <= 1'b1;
    end else if (soft_rst) begin
      nbit_q <= '0;
      frm_q  <= '0;
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      oe_q   <= 1'b0;
      out_q  <= 1'b1;
    end else begin
      nbit_q <= nbit_d;
      frm_q  <= frm_d;
      busy_q <= busy_d;
      rd_q   <= rd_d;
      oe_q   <= oe_d;
      out_q  <= out_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= '0;
    else        rx_q <= rx_d;
  end

  assign busy    = busy_q;
  assign mdio_o  = out_q;
  assign mdio_oe = oe_q;
  assign rd_done = done && rd_q;
  assign rx_data = rx_d;

  a_r8_softreset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !busy_q && !oe_q);
  a_r5_release_data: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && rd_q && nbit_q > N_TA |-> !oe_q);
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe
);
  logic        cfg_rst_q;
  logic [2:0]  cfg_code_q;
  logic [4:0]  phy_q, regn_q;
  logic [15:0] wdata_q, stat_q;
  logic        rdcmd_q;
  logic        start_wr, start_rd, start, busy, fall_p, rise_p, rd_done;
  logic [15:0] rx_data;
  logic        unused_ok;

  assign unused_ok = ^{reg_wdata[30:16], reg_wdata[7:5]};
  assign start_wr  = reg_wr && (reg_addr == RA_DATA) && !cfg_rst_q;
  assign start_rd  = reg_wr && (reg_addr == RA_CMD) && reg_wdata[0] &&
                     !rdcmd_q && !cfg_rst_q;
  assign start     = start_wr || start_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_rst_q  <= 1'b0;
      cfg_code_q <= '0;
      phy_q      <= '0;
      regn_q     <= '0;
      wdata_q    <= '0;
      rdcmd_q    <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        RA_CFG:  begin
          cfg_rst_q  <= reg_wdata[31];
          cfg_code_q <= reg_wdata[2:0];
        end
        RA_ADDR: begin
          phy_q  <= reg_wdata[12:8];
          regn_q <= reg_wdata[4:0];
        end
        RA_DATA: wdata_q <= reg_wdata[15:0];
        RA_CMD:  rdcmd_q <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (rd_done) stat_q <= rx_data;
  end

  always_comb begin
    case (reg_addr)
      RA_CFG:  reg_rdata = {cfg_rst_q, 28'd0, cfg_code_q};
      RA_ADDR: reg_rdata = {19'd0, phy_q, 3'd0, regn_q};
      RA_DATA: reg_rdata = {16'd0, wdata_q};
      RA_CMD:  reg_rdata = {31'd0, rdcmd_q};
      RA_IND:  reg_rdata = {31'd0, busy};
      RA_STAT: reg_rdata = {16'd0, stat_q};
      default: reg_rdata = '0;
    endcase
  end

  mdio_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .soft_rst(cfg_rst_q), .run(busy),
    .code(cfg_code_q), .mdc(mdc), .fall_p(fall_p), .rise_p(rise_p)
  );

  mdio_shifter u_shf (
    .clk(clk), .rst_n(rst_n), .soft_rst(cfg_rst_q), .start(start),
    .start_rd(start_rd), .phy(phy_q), .regn(regn_q), .wdata(reg_wdata[15:0]),
    .fall_p(fall_p), .rise_p(rise_p), .mdio_i(mdio_i), .busy(busy),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rd_done(rd_done), .rx_data(rx_data)
  );

  a_r9_mdio_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe && $past(mdio_oe) && !$stable(mdio_o) |-> $fell(mdc));
  a_r4_mdc_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> mdc);
endmodule

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int tests = 0, fails = 0;
  int rises = 0;
  int cyc = 0;
  logic [63:0] cap = '0;
  logic        phy_on = 1'b0;
  logic [15:0] phy_word = 16'h0;

  mdio_master uut (.*);

  always #5 clk = ~clk;
  always @(posedge clk) cyc = cyc + 1;

  always @(posedge mdc) begin
    rises = rises + 1;
    cap   = {cap[62:0], mdio_o};
  end

  always @(negedge mdc) begin
    if (phy_on && rises >= 48 && rises <= 63) mdio_i = phy_word[63 - rises];
    else mdio_i = 1'b1;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd4, v);
      if (v[0] == 1'b0) return;
    end
  endtask

  function automatic logic [63:0] wr_frame(input logic [4:0] p, input logic [4:0] r,
                                           input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd4, v); check(v[0] == 1'b0, "R1 busy", v, 0);
    rd(3'd5, v); check(v == 0, "R1 status", v, 0);
    check(mdc == 1'b1 && mdio_oe == 1'b0, "R1 pins", {mdc, mdio_oe}, 2'b10);
  endtask

  task automatic t_write(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    logic [31:0] v;
    wr(3'd1, {19'd0, p, 3'd0, r});
    rises = 0;
    wr(3'd2, {16'd0, d});
    rd(3'd4, v); check(v[0] == 1'b1, "R4 busy after launch", v, 1);
    wait_idle();
    check(rises == 64, "R4 rising edges per frame", rises, 64);
    check(cap == wr_frame(p, r, d), "R3 R11 write frame", cap, wr_frame(p, r, d));
    check(mdc == 1'b1, "R4 mdc idle high", mdc, 1);
  endtask

  task automatic t_read(input bit present, input logic [4:0] p, input logic [4:0] r,
                        input logic [15:0] w, input string tag);
    logic [31:0] v;
    logic [45:0] hdr;
    logic [15:0] exp;
    bit released;
    phy_on = present; phy_word = w;
    wr(3'd1, {19'd0, p, 3'd0, r});
    rises = 0;
    wr(3'd3, 32'd1);
    released = 1'b1;
    while (rises < 48) @(negedge clk);
    while (rises < 60) begin
      @(negedge clk);
      if (mdio_oe) released = 1'b0;
    end
    check(released, "R5 line released in data phase", {63'd0, released}, 1);
    wait_idle();
    hdr = {32'hFFFF_FFFF, 2'b01, 2'b10, p, r};
    check(cap[63:18] == hdr, "R5 read header", cap[63:18], hdr);
    exp = present ? w : 16'hFFFF;
    rd(3'd5, v);
    check(v[15:0] == exp, tag, v, exp);
  endtask

  task automatic t_edge_only();
    logic [31:0] v;
    int r0;
    r0 = rises;
    wr(3'd3, 32'd1);
    repeat (200) @(negedge clk);
    rd(3'd4, v);
    check(v[0] == 1'b0 && rises == r0, "R7 level does not relaunch", rises, r0);
    wr(3'd3, 32'd0);
    phy_on = 1'b1; phy_word = 16'h5A3C;
    rises = 0;
    wr(3'd3, 32'd1);
    rd(3'd4, v);
    check(v[0] == 1'b1, "R7 rising bit launches", v, 1);
    wait_idle();
    rd(3'd5, v);
    check(v[15:0] == 16'h5A3C, "R7 read data", v, 16'h5A3C);
    wr(3'd3, 32'd0);
  endtask

  task automatic t_period(input logic [2:0] code, input int exp);
    int c0, c1;
    wr(3'd0, {29'd0, code});
    wr(3'd2, 32'h1234);
    @(posedge mdc); c0 = cyc;
    @(posedge mdc); c1 = cyc;
    check(c1 - c0 == exp, "R2 mdc period", c1 - c0, exp);
    wait_idle();
  endtask

  task automatic t_busy_ignore();
    wr(3'd1, {19'd0, 5'h03, 3'd0, 5'h07});
    rises = 0;
    wr(3'd2, 32'h0000_A5A5);
    repeat (300) @(negedge clk);
    wr(3'd2, 32'h0000_3C3C);
    wr(3'd3, 32'd1);
    wait_idle();
    check(cap == wr_frame(5'h03, 5'h07, 16'hA5A5), "R10 frame unchanged", cap,
          wr_frame(5'h03, 5'h07, 16'hA5A5));
    check(rises == 64, "R10 single frame", rises, 64);
    wr(3'd3, 32'd0);
  endtask

  task automatic t_soft_reset();
    logic [31:0] v;
    wr(3'd2, 32'h0000_BEEF);
    repeat (500) @(negedge clk);
    wr(3'd0, 32'h8000_0001);
    rd(3'd4, v);
    check(v[0] == 1'b0 && mdc == 1'b1 && mdio_oe == 1'b0, "R8 held idle",
          {v[0], mdc, mdio_oe}, 3'b010);
    wr(3'd2, 32'h0000_1111);
    repeat (100) @(negedge clk);
    rd(3'd4, v);
    check(v[0] == 1'b0, "R8 no launch in reset", v, 0);
    wr(3'd0, 32'h0000_0001);
    t_write(5'h1F, 5'h00, 16'h0F0F);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    wr(3'd0, 32'h1);
    t_write(5'h15, 5'h0A, 16'hC3E1);
    t_write(5'h00, 5'h1F, 16'h8001);
    t_read(1'b1, 5'h0B, 5'h11, 16'h9D27, "R5 read data");
    t_edge_only();
    wr(3'd3, 32'd0);
    t_read(1'b0, 5'h1E, 5'h02, 16'h0000, "R6 no PHY returns ones");
    wr(3'd3, 32'd0);
    t_busy_ignore();
    t_soft_reset();
    t_period(3'd2, 48);
    t_period(3'd5, 112);
    t_period(3'd0, 224);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_800_000;
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule